// File: doc/BRIEF.md
# Segment Address Translator

This block turns a logical address, given as a segment index and an offset, into a physical address. It keeps a small table of segment descriptors in its own registers. Each descriptor holds a physical start address, a segment length, a present flag and three access-right flags (read, write, execute). A separate count register says how many table slots the current program uses. Software-side logic loads the table and the count through a simple write port.

A request carries the segment index, the offset and the kind of access. One cycle after the request is accepted, the block returns either the physical address or a fault code that names the first check that failed. The checks run in a fixed order: segment count, then present flag, then length, then access rights. A small two-state controller owns the handshake. `ST_IDLE` accepts a request (`req_ready` high) and moves to `ST_RESP`. `ST_RESP` presents the response (`rsp_valid` high) and goes back to `ST_IDLE` once `rsp_ready` is seen. Otherwise it stays in `ST_RESP` with the response frozen.

Top module: `seg_xlate`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, the segment count is 0 and every slot is absent. A request issued before any load therefore returns fault code 1.
- R2: A request whose segment index is not strictly less than the segment count returns fault code 1, whatever the slot holds.
- R3: A request to a slot whose present flag is 0 returns fault code 2. This check is made only after R2 passes.
- R4: An offset equal to or greater than the slot's length returns fault code 3. This check is made only after R2 and R3 pass.
- R5: The access code is 0 for read, 1 for write and 2 for execute. Permission bit i of a slot (bit 0 read, bit 1 write, bit 2 execute) allows access code i. An access whose bit is 0 returns fault code 4, after R2 to R4 pass.
- R6: When every check passes, the fault code is 0 and `rsp_paddr` equals the slot's start address plus the offset, modulo 2^PA_W.
- R7: Whenever the fault code is nonzero, `rsp_paddr` is 0.
- R8: `rsp_valid` is 1 in the cycle right after a request is accepted (`req_valid` and `req_ready` both high at a clock edge). `req_ready` stays 0 while a response is pending.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, the response keeps its fault code and address. The response is dropped on the edge after `rsp_ready` is seen.
- R10: A slot write or count write issued in the same cycle as an accepted request does not affect that request's response. It does affect the next request.
- R11: Access code 3 is reserved. It returns fault code 4 once R2 to R4 pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Write one table slot |
| tbl_idx | input | SEG_W | Slot to write |
| tbl_base | input | PA_W | Physical start address of the slot |
| tbl_len | input | OFF_W+1 | Segment length |
| tbl_present | input | 1 | Present flag |
| tbl_perm | input | 3 | Rights: bit0 read, bit1 write, bit2 execute |
| cnt_we | input | 1 | Write the segment count |
| cnt_val | input | SEG_W+1 | New segment count |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_seg | input | SEG_W | Segment index |
| req_off | input | OFF_W | Offset inside segment |
| req_acc | input | 2 | Access code |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_fault | output | 3 | Fault code 0..4 |
| rsp_paddr | output | PA_W | Physical address, 0 on fault |

## Verification
A table load and a translation can land in the same cycle. The new descriptor or count then collides with a lookup that reads the old one. The bench raises `req_valid` together with a slot write that clears the present flag, and separately together with a count write that shrinks the count below the requested index. The response in flight must show the old, passing result, and the request right after it must show fault code 2 or 1 respectively.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_RANGE   = 3'd1,
        FLT_ABSENT  = 3'd2,
        FLT_LENGTH  = 3'd3,
        FLT_RIGHTS  = 3'd4
    } fault_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } state_e;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
    parameter int SEG_W = 3,
    parameter int OFF_W = 12,
    parameter int PA_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tbl_we,
    input  logic [SEG_W-1:0]    tbl_idx,
    input  logic [PA_W-1:0]     tbl_base,
    input  logic [OFF_W:0]      tbl_len,
    input  logic                tbl_present,
    input  logic [2:0]          tbl_perm,
    input  logic                cnt_we,
    input  logic [SEG_W:0]      cnt_val,
    input  logic [SEG_W-1:0]    rd_idx,
    output logic [PA_W-1:0]     rd_base,
    output logic [OFF_W:0]      rd_len,
    output logic                rd_present,
    output logic [2:0]          rd_perm,
    output logic [SEG_W:0]      seg_count
);
    localparam int NSEG = 1 << SEG_W;

    logic [PA_W-1:0]  base_q    [NSEG];
    logic [OFF_W:0]   len_q     [NSEG];
    logic             present_q [NSEG];
    logic [2:0]       perm_q    [NSEG];
    logic [SEG_W:0]   count_q;

    for (genvar g = 0; g < NSEG; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[g]    <= '0;
                len_q[g]     <= '0;
                present_q[g] <= 1'b0;
                perm_q[g]    <= '0;
            end else if (tbl_we && tbl_idx == SEG_W'(g)) begin
                base_q[g]    <= tbl_base;
                len_q[g]     <= tbl_len;
                present_q[g] <= tbl_present;
                perm_q[g]    <= tbl_perm;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      count_q <= '0;
        else if (cnt_we) count_q <= cnt_val;
    end

    assign rd_base    = base_q[rd_idx];
    assign rd_len     = len_q[rd_idx];
    assign rd_present = present_q[rd_idx];
    assign rd_perm    = perm_q[rd_idx];
    assign seg_count  = count_q;
endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W = 3,
    parameter int OFF_W = 12,
    parameter int PA_W  = 16
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       acc,
    input  logic [SEG_W:0]   seg_count,
    input  logic [PA_W-1:0]  base,
    input  logic [OFF_W:0]   len,
    input  logic             present,
    input  logic [2:0]       perm,
    output logic [2:0]       fault,
    output logic [PA_W-1:0]  paddr
);
    logic allowed;

    always_comb begin
        unique case (acc_e'(acc))
            ACC_READ:  allowed = perm[0];
            ACC_WRITE: allowed = perm[1];
            ACC_EXEC:  allowed = perm[2];
            default:   allowed = 1'b0;
        endcase
    end

    always_comb begin
        paddr = '0;
        if ({1'b0, seg} >= seg_count)   fault = FLT_RANGE;
        else if (!present)              fault = FLT_ABSENT;
        else if ({1'b0, off} >= len)    fault = FLT_LENGTH;
        else if (!allowed)              fault = FLT_RIGHTS;
        else begin
            fault = FLT_NONE;
            paddr = base + PA_W'(off);
        end
    end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W = 3,
    parameter int OFF_W = 12,
    parameter int PA_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tbl_we,
    input  logic [SEG_W-1:0] tbl_idx,
    input  logic [PA_W-1:0]  tbl_base,
    input  logic [OFF_W:0]   tbl_len,
    input  logic             tbl_present,
    input  logic [2:0]       tbl_perm,
    input  logic             cnt_we,
    input  logic [SEG_W:0]   cnt_val,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [SEG_W-1:0] req_seg,
    input  logic [OFF_W-1:0] req_off,
    input  logic [1:0]       req_acc,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [2:0]       rsp_fault,
    output logic [PA_W-1:0]  rsp_paddr
);
    state_e           state_q, state_d;
    logic [PA_W-1:0]  ent_base;
    logic [OFF_W:0]   ent_len;
    logic             ent_present;
    logic [2:0]       ent_perm;
    logic [SEG_W:0]   seg_count;
    logic [2:0]       chk_fault;
    logic [PA_W-1:0]  chk_paddr;
    logic [2:0]       fault_q;
    logic [PA_W-1:0]  paddr_q;
    logic             accept;

    seg_table #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_base(tbl_base),
        .tbl_len(tbl_len), .tbl_present(tbl_present), .tbl_perm(tbl_perm),
        .cnt_we(cnt_we), .cnt_val(cnt_val),
        .rd_idx(req_seg), .rd_base(ent_base), .rd_len(ent_len),
        .rd_present(ent_present), .rd_perm(ent_perm), .seg_count(seg_count)
    );

    seg_check #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_check (
        .seg(req_seg), .off(req_off), .acc(req_acc), .seg_count(seg_count),
        .base(ent_base), .len(ent_len), .present(ent_present), .perm(ent_perm),
        .fault(chk_fault), .paddr(chk_paddr)
    );

    assign accept = req_valid && (state_q == ST_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;
            ST_RESP: if (rsp_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // response data, captured from the table as it stands at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= '0;
            paddr_q <= '0;
        end else if (accept) begin
            fault_q <= chk_fault;
            paddr_q <= chk_paddr;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin req_ready = 1'b1; rsp_valid = 1'b0; end
            ST_RESP: begin req_ready = 1'b0; rsp_valid = 1'b1; end
            default: begin req_ready = 1'b0; rsp_valid = 1'b0; end
        endcase
    end

    assign rsp_fault = fault_q;
    assign rsp_paddr = paddr_q;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int PA_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic [2:0]      rsp_fault,
    input logic [PA_W-1:0] rsp_paddr
);
    // R8
    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);
    // R8
    a_r8_no_ready_pending: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
    // R9
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_fault) && $stable(rsp_paddr)));
    // R9
    a_r9_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> !rsp_valid);
    // R7
    a_r7_zero_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 3'd0) |-> rsp_paddr == '0);
    // R2 R3 R4 R5: only defined codes
    a_r5_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_fault <= 3'd4);
endmodule

bind seg_xlate seg_xlate_chk #(.PA_W(PA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
);

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
    localparam int SEG_W = 3;
    localparam int OFF_W = 12;
    localparam int PA_W  = 16;
    localparam int NVEC  = 15;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tbl_we = 1'b0;
    logic [SEG_W-1:0] tbl_idx = '0;
    logic [PA_W-1:0]  tbl_base = '0;
    logic [OFF_W:0]   tbl_len = '0;
    logic             tbl_present = 1'b0;
    logic [2:0]       tbl_perm = '0;
    logic             cnt_we = 1'b0;
    logic [SEG_W:0]   cnt_val = '0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [SEG_W-1:0] req_seg = '0;
    logic [OFF_W-1:0] req_off = '0;
    logic [1:0]       req_acc = '0;
    logic             rsp_valid;
    logic             rsp_ready = 1'b1;
    logic [2:0]       rsp_fault;
    logic [PA_W-1:0]  rsp_paddr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    seg_xlate #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_seg_xlate (.*);

    // {seg[3], off[12], acc[2], fault[3], paddr[16]}
    localparam logic [35:0] VEC [NVEC] = '{
        {3'd0, 12'h010, 2'd0, 3'd0, 16'h1010},   // R6
        {3'd0, 12'h0FF, 2'd2, 3'd0, 16'h10FF},   // R6 last offset
        {3'd0, 12'h100, 2'd0, 3'd3, 16'h0000},   // R4 at length
        {3'd0, 12'h010, 2'd1, 3'd4, 16'h0000},   // R5 write denied
        {3'd1, 12'h7FF, 2'd1, 3'd0, 16'h27FF},   // R6
        {3'd1, 12'h020, 2'd2, 3'd4, 16'h0000},   // R5 exec denied
        {3'd1, 12'h800, 2'd2, 3'd3, 16'h0000},   // R4 before R5
        {3'd2, 12'h000, 2'd0, 3'd2, 16'h0000},   // R3
        {3'd2, 12'h100, 2'd2, 3'd2, 16'h0000},   // R3 before R4
        {3'd3, 12'hFFF, 2'd0, 3'd0, 16'h0EFF},   // R6 wrap
        {3'd3, 12'h200, 2'd1, 3'd0, 16'h0100},   // R6 wrap
        {3'd3, 12'h010, 2'd3, 3'd4, 16'h0000},   // R11 reserved
        {3'd4, 12'h000, 2'd0, 3'd1, 16'h0000},   // R2 index equals count
        {3'd5, 12'h000, 2'd0, 3'd1, 16'h0000},   // R2 present slot beyond count
        {3'd7, 12'hFFF, 2'd3, 3'd1, 16'h0000}    // R2 before all
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input int idx, input logic [PA_W-1:0] b, input logic [OFF_W:0] l,
                        input logic p, input logic [2:0] pm);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = SEG_W'(idx); tbl_base = b; tbl_len = l;
        tbl_present = p; tbl_perm = pm;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic set_count(input logic [SEG_W:0] c);
        @(negedge clk);
        cnt_we = 1'b1; cnt_val = c;
        @(negedge clk);
        cnt_we = 1'b0;
    endtask

    // drives at a negedge; request accepted at the next posedge
    task automatic issue(input logic [SEG_W-1:0] s, input logic [OFF_W-1:0] o, input logic [1:0] a);
        req_valid = 1'b1; req_seg = s; req_off = o; req_acc = a;
    endtask

    task automatic xlate(input string req, input logic [SEG_W-1:0] s, input logic [OFF_W-1:0] o,
                         input logic [1:0] a, input logic [2:0] ef, input logic [PA_W-1:0] ea);
        @(negedge clk);
        issue(s, o, a);
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " R8 rsp_valid"}, 32'(rsp_valid), 32'd1);
        check({req, " fault"}, 32'(rsp_fault), 32'(ef));
        check({req, " paddr"}, 32'(rsp_paddr), 32'(ea));
        @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 req_ready", 32'(req_ready), 32'd1);
        check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        xlate("R1 empty table", 3'd0, 12'h000, 2'd0, 3'd1, 16'h0);

        load(0, 16'h1000, 13'h0100, 1'b1, 3'b101);
        load(1, 16'h2000, 13'h0800, 1'b1, 3'b011);
        load(2, 16'h3000, 13'h0040, 1'b0, 3'b111);
        load(3, 16'hFF00, 13'h1000, 1'b1, 3'b111);
        load(5, 16'h5000, 13'h1000, 1'b1, 3'b111);
        xlate("R2 count still zero", 3'd0, 12'h010, 2'd0, 3'd1, 16'h0);
        set_count(4'd4);

        for (int i = 0; i < NVEC; i++) begin
            xlate($sformatf("vec%0d R2 R3 R4 R5 R6 R7 R11", i),
                  VEC[i][35:33], VEC[i][32:21], VEC[i][20:19], VEC[i][18:16], VEC[i][15:0]);
        end

        // R9 backpressure
        @(negedge clk);
        rsp_ready = 1'b0;
        issue(3'd1, 12'h044, 2'd0);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            check("R9 held valid", 32'(rsp_valid), 32'd1);
            check("R8 ready low while pending", 32'(req_ready), 32'd0);
            check("R9 held paddr", 32'(rsp_paddr), 32'h2044);
            @(negedge clk);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        check("R9 dropped after ready", 32'(rsp_valid), 32'd0);

        // R10 slot write in same cycle as accepted request
        @(negedge clk);
        issue(3'd1, 12'h010, 2'd0);
        tbl_we = 1'b1; tbl_idx = 3'd1; tbl_base = 16'h2000; tbl_len = 13'h0800;
        tbl_present = 1'b0; tbl_perm = 3'b011;
        @(negedge clk);
        req_valid = 1'b0; tbl_we = 1'b0;
        check("R10 old slot fault", 32'(rsp_fault), 32'd0);
        check("R10 old slot paddr", 32'(rsp_paddr), 32'h2010);
        @(posedge clk);
        xlate("R10 new slot visible", 3'd1, 12'h010, 2'd0, 3'd2, 16'h0);

        // R10 count write in same cycle as accepted request
        @(negedge clk);
        issue(3'd3, 12'h001, 2'd0);
        cnt_we = 1'b1; cnt_val = 4'd2;
        @(negedge clk);
        req_valid = 1'b0; cnt_we = 1'b0;
        check("R10 old count fault", 32'(rsp_fault), 32'd0);
        check("R10 old count paddr", 32'(rsp_paddr), 32'hFF01);
        @(posedge clk);
        xlate("R10 new count visible", 3'd3, 12'h001, 2'd0, 3'd1, 16'h0);

        // R1 reset clears the table again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        set_count(4'd8);
        xlate("R1 slots absent after reset", 3'd0, 12'h000, 2'd0, 3'd2, 16'h0);

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule